// File: doc/BRIEF.md
# Seven-Input Converter Serial Port

This block is the device-side digital port of a seven-input, 12-bit successive-approximation converter. It sits in a fast system clock domain and oversamples the three host-driven wires: an active-low select, a serial clock and a serial data input. It drives a serial data output with an enable that stands in for the high-impedance state. The block stands in for the converter front end, so the value of each input channel arrives on a parallel bus.

A host pulls select low and then clocks groups of sixteen serial-clock cycles. In each group it writes an 8-bit control byte and reads back a 16-bit word. The word holds four zero bits and then the 12-bit result of the channel named in the previous group. The block also shows when the sampling stage is tracking and when the converter would be powered down.

Top module: `adc_serial_port`

## Requirements
- R1: A falling edge of `cs_n_i` opens a frame and sets `sdo_en_o` high. A rising edge sets `sdo_en_o` low. While `sdo_en_o` is low, `sdo_o` is 0.
- R2: Each conversion spans exactly 16 serial-clock cycles. While `cs_n_i` stays low, conversions follow one another with no idle cycle between them.
- R3: The output word is four 0 bits and then 12 result bits, MSB first. Output bit k (k = 1..16) is updated on the k-th falling edge of the conversion and is read just before the k-th rising edge.
- R4: `sdi_i` is shifted into an 8-bit control byte, first bit as bit 7, on rising edges 1 to 8 of each conversion. Rising edges 9 to 16 do not change the byte.
- R5: Control bits 5:3 are the channel address: the 3rd, 4th and 5th serial bits, the 3rd being the MSB. The other five bits have no effect.
- R6: Address 0 to 6 selects `ch_data_i` slice 0 to 6 (bits [12*a+11:12*a]). Address 7 returns 0.
- R7: The address written in one conversion selects the channel of the next conversion. After reset the control byte is 0, so the first conversion returns slice 0.
- R8: `track_o` is high after falling edges 1 to 3 of a conversion. The channel value is latched on the 4th falling edge; later changes of `ch_data_i` do not alter that conversion.
- R9: Serial-clock edges while `cs_n_i` is high are ignored. If the serial clock is low when `cs_n_i` falls, that select edge counts as the first falling edge.
- R10: `pdown_o` is high while `cs_n_i` is high. It is also high from the 16th falling edge of a conversion until the first falling edge of the next.
- R11: A rise of `cs_n_i` before the 16th falling edge aborts the conversion and leaves the control byte unchanged.
- R12: After reset, `sdo_en_o`=0, `sdo_o`=0, `track_o`=0 and `pdown_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial control data from the host |
| ch_data_i | input | 84 | Seven packed 12-bit channel values |
| sdo_o | output | 1 | Serial result data |
| sdo_en_o | output | 1 | Output drive enable (low means high impedance) |
| track_o | output | 1 | Sampling stage is tracking |
| pdown_o | output | 1 | Converter is powered down |

## Verification
The bench sweeps every address, both in long back-to-back frames and in one-conversion frames that start with the serial clock idling low. A design without the one-sample delay, or one that lost the select-edge-as-first-fall rule, would return the wrong channel or a word shifted by one bit. Junk bits on the last eight rising edges would overwrite the address in a design that kept shifting. A mid-frame abort that committed a half-written byte would show up as the wrong channel in the next frame. The bench flips the channel inputs after the hold edge, which exposes a design that samples late. It also toggles the serial clock while select is high, which corrupts the bit count of an ungated design.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int CH_NUM    = 7,
  parameter int RES_W     = 12,
  parameter int LEAD_W    = 4,
  parameter int CTRL_W    = 8,
  parameter int ADDR_LSB  = 3,
  parameter int ADDR_W    = 3,
  parameter int CAP_EDGES = 8,
  parameter int TRACK_CYC = 3,
  parameter int SYNC_LEN  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n_i,
  input  logic                    sclk_i,
  input  logic                    sdi_i,
  input  logic [CH_NUM*RES_W-1:0] ch_data_i,
  output logic                    sdo_o,
  output logic                    sdo_en_o,
  output logic                    track_o,
  output logic                    pdown_o
);
  localparam int FRAME_LEN = LEAD_W + RES_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int HOLD_EDGE = TRACK_CYC + 1;

  logic [SYNC_LEN-1:0] cs_sy, sclk_sy, sdi_sy;
  logic cs_q, sclk_q;
  logic active;
  logic [CNT_W-1:0]  fall_cnt;
  logic [CTRL_W-1:0] ctrl_q, cap_sr;
  logic [RES_W-1:0]  out_sr, sel_val;
  logic sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy   <= '1;
      sclk_sy <= '0;
      sdi_sy  <= '0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      cs_sy   <= {cs_sy[SYNC_LEN-2:0], cs_n_i};
      sclk_sy <= {sclk_sy[SYNC_LEN-2:0], sclk_i};
      sdi_sy  <= {sdi_sy[SYNC_LEN-2:0], sdi_i};
      cs_q    <= cs_sy[SYNC_LEN-1];
      sclk_q  <= sclk_sy[SYNC_LEN-1];
    end
  end

  wire cs_s   = cs_sy[SYNC_LEN-1];
  wire sclk_s = sclk_sy[SYNC_LEN-1];
  wire sdi_s  = sdi_sy[SYNC_LEN-1];

  wire cs_fall     = cs_q & ~cs_s;
  wire cs_rise     = ~cs_q & cs_s;
  wire cs_low      = ~cs_q & ~cs_s;
  wire sck_fall    = cs_low & sclk_q & ~sclk_s;
  wire sck_rise    = cs_low & ~sclk_q & sclk_s;
  wire first_by_cs = cs_fall & ~sclk_s;

  wire conv_start = (fall_cnt == CNT_W'(FRAME_LEN)) || (fall_cnt == '0);
  wire [CNT_W-1:0] next_cnt = conv_start ? CNT_W'(1) : fall_cnt + CNT_W'(1);
  wire cap_win = (fall_cnt != '0) && (fall_cnt <= CNT_W'(CAP_EDGES));

  wire [ADDR_W-1:0] addr = ctrl_q[ADDR_LSB +: ADDR_W];

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < CH_NUM; i++)
      if (addr == ADDR_W'(i)) sel_val = ch_data_i[i*RES_W +: RES_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      fall_cnt <= '0;
      ctrl_q   <= '0;
      cap_sr   <= '0;
      out_sr   <= '0;
      sdo_q    <= 1'b0;
    end else if (cs_rise) begin
      active   <= 1'b0;
      fall_cnt <= '0;
      sdo_q    <= 1'b0;
    end else if (cs_fall) begin
      active   <= 1'b1;
      sdo_q    <= 1'b0;
      fall_cnt <= first_by_cs ? CNT_W'(1) : '0;
    end else if (sck_fall) begin
      fall_cnt <= next_cnt;
      if (next_cnt == CNT_W'(HOLD_EDGE)) out_sr <= sel_val;
      if (next_cnt > CNT_W'(LEAD_W)) begin
        sdo_q  <= out_sr[RES_W-1];
        out_sr <= out_sr << 1;
      end else begin
        sdo_q <= 1'b0;
      end
      if (next_cnt == CNT_W'(FRAME_LEN)) ctrl_q <= cap_sr;
    end else if (sck_rise && cap_win) begin
      cap_sr <= {cap_sr[CTRL_W-2:0], sdi_s};
    end
  end

  assign sdo_en_o = active;
  assign sdo_o    = sdo_q & active;
  assign track_o  = active && (fall_cnt != '0) && (fall_cnt <= CNT_W'(TRACK_CYC));
  assign pdown_o  = ~active | (fall_cnt == CNT_W'(FRAME_LEN));
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int CTRL_W    = 8,
  parameter int CNT_W     = 5,
  parameter int FRAME_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo_o,
  input logic              sdo_en_o,
  input logic              track_o,
  input logic              pdown_o,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  fall_cnt
);
  // R1
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en_o |-> !sdo_o);
  // R10
  idle_pdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en_o |-> pdown_o);
  // R8
  track_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    track_o |-> (!pdown_o && sdo_en_o));
  // R8
  track_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_o) |-> (fall_cnt == CNT_W'(1)));
  // R11
  ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> (fall_cnt == CNT_W'(FRAME_LEN)));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= CNT_W'(FRAME_LEN));
endmodule

bind adc_serial_port adc_serial_port_chk #(
  .CTRL_W(CTRL_W), .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o),
  .track_o(track_o), .pdown_o(pdown_o), .ctrl_q(ctrl_q), .fall_cnt(fall_cnt)
);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam int CH = 7;
  localparam int RW = 12;
  localparam int HP = 6;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sclk = 1, sdi = 0;
  logic [CH*RW-1:0] ch_bus;
  logic sdo, sdo_en, track, pdown;
  int n_chk = 0, n_bad = 0;
  logic [2:0] model_addr = 3'd0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .ch_data_i(ch_bus), .sdo_o(sdo), .sdo_en_o(sdo_en), .track_o(track),
    .pdown_o(pdown)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [RW-1:0] chval(input logic [2:0] a);
    return (a < 3'd7) ? ch_bus[a*RW +: RW] : '0;
  endfunction

  // one conversion of ncyc serial cycles; din[15:8] on rises 1..8, din[7:0] junk on 9..16
  task automatic conv(input logic [15:0] din, input bit cs_first, input int ncyc,
                      input bit poke);
    logic [15:0] word = '0;
    logic [15:0] exp  = {4'b0, chval(model_addr)};
    logic [CH*RW-1:0] saved = ch_bus;
    bit trk_ok = 1, pd_ok = 1, en_ok = 1;
    for (int k = 1; k <= ncyc; k++) begin
      if (!(k == 1 && cs_first)) sclk = 0;
      sdi = din[16-k];
      waitn(HP);
      word[16-k] = sdo;
      if (track !== (k <= 3)) trk_ok = 0;
      if (pdown !== (k == 16)) pd_ok = 0;
      if (sdo_en !== 1'b1) en_ok = 0;
      if (poke && k == 6) ch_bus = ~ch_bus;
      sclk = 1;
      waitn(HP);
    end
    ch_bus = saved;
    chk(en_ok, "R1 enable during frame", 0, 1);
    chk(trk_ok, "R8 track window", 0, 1);
    if (ncyc == 16) begin
      chk(pd_ok, "R10 power-down between conversions", 0, 1);
      chk(word === exp, "R3/R6/R7 result word", word, exp);
      model_addr = din[13:11];
    end
  endtask

  task automatic open_frame(input bit idle_low);
    sclk = idle_low ? 1'b0 : 1'b1;
    waitn(HP);
    cs_n = 0;
    if (!idle_low) waitn(HP);
  endtask

  task automatic close_frame();
    waitn(HP);
    cs_n = 1;
    waitn(2*HP);
    chk(!sdo_en && pdown && !sdo, "R1/R10 idle after frame", {sdo_en, pdown, sdo}, 3'b010);
  endtask

  initial begin
    for (int i = 0; i < CH; i++)
      ch_bus[i*RW +: RW] = (i == 6) ? 12'hFFF : 12'(12'h3A5 + i * 12'h2C7);
    waitn(4);
    chk(!sdo_en && !sdo && !track && pdown, "R12 reset outputs",
        {sdo_en, sdo, track, pdown}, 4'b0001);
    rst_n = 1;
    waitn(4);
    chk(!sdo_en && pdown, "R12 idle after reset", {sdo_en, pdown}, 2'b01);

    // R2 R5 R7 back-to-back sweep, clock idling high, don't-care bits set
    open_frame(0);
    for (int a = 0; a <= 8; a++) begin
      logic [7:0] b = {2'b11, 3'(a % 8), 3'b101};
      if (a % 2 == 1) b = {2'b00, 3'(a % 8), 3'b010};
      conv({b, 8'h00}, 0, 16, 0);
    end
    close_frame();

    // R9 R6 single-conversion frames with clock idling low
    for (int a = 7; a >= 0; a--) begin
      open_frame(1);
      conv({2'b01, 3'(a), 3'b110, 8'hFF}, 1, 16, 0);
      close_frame();
    end
    open_frame(1);
    conv(16'h0000, 1, 16, 0);
    close_frame();

    // R4 junk after eighth rising edge must not become the address
    open_frame(0);
    conv({8'(3'd2 << 3), 8'(3'd5 << 3)}, 0, 16, 0);
    conv({8'(3'd4 << 3), 8'hFF}, 0, 16, 0);
    conv(16'h0000, 0, 16, 0);
    close_frame();

    // R11 abort mid-frame keeps previous control byte
    open_frame(0);
    conv({8'(3'd3 << 3), 8'h00}, 0, 16, 0);
    close_frame();
    open_frame(0);
    conv({8'(3'd6 << 3), 8'h00}, 0, 10, 0);
    close_frame();
    open_frame(1);
    conv(16'h0000, 1, 16, 0);
    close_frame();

    // R8 inputs change after the hold edge
    open_frame(0);
    conv({8'(3'd5 << 3), 8'h00}, 0, 16, 0);
    conv({8'(3'd1 << 3), 8'h00}, 0, 16, 1);
    conv(16'h0000, 0, 16, 1);
    close_frame();

    // R9 clock toggles while select is high are ignored
    for (int t = 0; t < 5; t++) begin
      sclk = 0; waitn(HP);
      sclk = 1; waitn(HP);
    end
    chk(!sdo_en && pdown && !track, "R9 gated clock while idle",
        {sdo_en, pdown, track}, 3'b010);
    open_frame(0);
    conv({8'(3'd6 << 3), 8'h00}, 0, 16, 0);
    conv(16'h0000, 0, 16, 0);
    close_frame();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule